// File: doc/BRIEF.md
# DMA Command to Memory Request Splitter

The block takes one DMA command at a time. A command is a byte-granular start address, a byte count and a direction. The block breaks the command into a sequence of memory request descriptors for a downstream header builder. Each descriptor carries a DW-aligned address, a length in DWs, enables for the first and last DW, a request tag and the direction bit. Byte offsets that are not DW aligned appear only in the byte enables. Each chunk is cut so that it never crosses a 4 KB page. A chunk also never exceeds the size limit that applies to its direction: the maximum payload size for writes and the maximum read request size for reads.

Commands enter through a valid/ready handshake and descriptors leave through another. When the last descriptor of a command has been taken, `done` pulses for one cycle. A command with a zero byte count produces no descriptors and only the `done` pulse. Tags advance by one per descriptor, wrapping at 256 or, when extended tags are enabled, at 1024.

Top module: `dma_req_splitter`

## Requirements
- R1: `cmd_ready` is high exactly when no command is in progress. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. The direction and the applicable size code are sampled in that same cycle.
- R2: Every descriptor address has bits [1:0] equal to zero and equals the start byte address of its chunk with those two bits cleared. Each chunk starts at the byte that follows the previous chunk.
- R3: No descriptor crosses a 4 KB boundary: req_addr[11:0] + 4*req_len_dw <= 4096.
- R4: The size limit is 128 << code for codes 0 to 4, and 4096 for codes 5 to 7. The code is `mps_code` for writes and `mrrs_code` for reads. The chunk size is the minimum of three values: the remaining bytes, the bytes left to the next 4 KB boundary, and the limit minus the start byte offset within the DW. As a result, 4*req_len_dw never exceeds the limit.
- R5: req_len_dw = ceil((offset + chunk bytes)/4). When the length is 1, req_last_be is 4'b0000 and req_first_be has bit i set exactly for the bytes the chunk covers. For example, an aligned 4-byte chunk gives 4'b1111 and a single byte at offset 2 gives 4'b0100.
- R6: When the length is 2 or more, req_first_be sets bits offset..3 and req_last_be sets bits 0..e, where e is the offset of the final byte within its DW. The DWs in between are fully valid.
- R7: Each accepted descriptor carries a tag one higher than the previous one, and the first tag after reset is 0. With `ext_tag_en` low the count wraps modulo 256 and the upper tag bits are 0. With `ext_tag_en` high it wraps modulo 1024.
- R8: While `req_valid` is high and `req_ready` is low, the descriptor stays valid and unchanged.
- R9: `done` is high for one cycle, in the cycle after the handshake of a command's last descriptor. For a zero byte count it is high in the cycle after acceptance, and no descriptor is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Splitter idle and able to take a command |
| cmd_addr | input | 64 | Start byte address |
| cmd_bytes | input | 32 | Byte count |
| cmd_write | input | 1 | 1 = write, 0 = read |
| mps_code | input | 3 | Write payload limit code |
| mrrs_code | input | 3 | Read request limit code |
| ext_tag_en | input | 1 | Selects 10-bit tag wrap |
| req_valid | output | 1 | Descriptor offered |
| req_ready | input | 1 | Descriptor taken |
| req_addr | output | 64 | DW-aligned request address |
| req_len_dw | output | 11 | Length in DWs (1..1024) |
| req_first_be | output | 4 | First DW byte enables |
| req_last_be | output | 4 | Last DW byte enables |
| req_tag | output | 10 | Request tag |
| req_write | output | 1 | Direction of the descriptor |
| done | output | 1 | One-cycle pulse at command end |

## Verification
The assertions check the following on every cycle: the page bound, the length against the latched limit, the zero last enable on single-DW requests, the contiguous enable shapes on longer requests, descriptor stability under backpressure, and that no descriptor is offered while idle. Some behaviours can only be shown by the bench's scenarios, which compare each descriptor against a model built from the requirements. These are the exact chunk sizes and their order, the address continuity between descriptors, the tag sequence across the 256 and 1024 wraps, the timing of `done`, and the silent zero-length command.

// File: rtl/dreq_pkg.sv
// Shared types and helpers for the DMA request splitter.
// Assumes a 4 KB page and a 4096-byte absolute transfer limit.
package dreq_pkg;
    localparam int PAGE_LG = 12;
    localparam int CHK_W   = PAGE_LG + 1;

    typedef enum logic {ST_IDLE, ST_BUSY} split_st_e;

    // Converts a 3-bit size code into a byte limit (128..4096).
    function automatic logic [CHK_W-1:0] limit_of(input logic [2:0] code);
        if (code >= 3'd5) return CHK_W'(1 << PAGE_LG);
        return CHK_W'(128) << code;
    endfunction
endpackage

// File: rtl/dreq_chunk_calc.sv
// Works out the size of the next chunk and its DW span from the current
// byte address, the remaining bytes and the direction's byte limit.
// Assumes remain > 0 whenever the result is used, and limit >= 128.
module dreq_chunk_calc #(
    parameter int ADDR_W  = 64,
    parameter int CNT_W   = 32,
    parameter int PAGE_LG = 12,
    localparam int CHK_W  = PAGE_LG + 1,
    localparam int LEN_W  = PAGE_LG - 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  remain,
    input  logic [CHK_W-1:0]  limit,
    output logic [CHK_W-1:0]  chunk,
    output logic [LEN_W-1:0]  len_dw,
    output logic [1:0]        off,
    output logic [1:0]        end_off
);
    logic [CHK_W-1:0] to_page;
    logic [CHK_W-1:0] lim_room;
    logic [CHK_W-1:0] bound;
    logic [CHK_W-1:0] span;
    logic [CHK_W-1:0] span_up;

    // Chunk = min(remaining, room to page end, limit less start offset).
    always_comb begin
        off      = addr[1:0];
        to_page  = CHK_W'(1 << PAGE_LG) - {1'b0, addr[PAGE_LG-1:0]};
        lim_room = limit - CHK_W'(off);
        bound    = (to_page < lim_room) ? to_page : lim_room;
        chunk    = (remain < CNT_W'(bound)) ? remain[CHK_W-1:0] : bound;
        span     = CHK_W'(off) + chunk;
        span_up  = span + CHK_W'(3);
        len_dw   = span_up[CHK_W-1:2];
        end_off  = 2'(span - CHK_W'(1));
    end
endmodule

// File: rtl/dreq_be_gen.sv
// Forms first and last DW byte enables from the start offset, the final
// byte offset and whether the request is a single DW.
module dreq_be_gen (
    input  logic [1:0] off,
    input  logic [1:0] end_off,
    input  logic       single,
    output logic [3:0] first_be,
    output logic [3:0] last_be
);
    logic [3:0] lo_mask;
    logic [3:0] hi_mask;

    // Lower mask opens at the start byte, upper mask closes at the end byte.
    always_comb begin
        lo_mask  = 4'hF << off;
        hi_mask  = 4'hF >> (2'd3 - end_off);
        first_be = single ? (lo_mask & hi_mask) : lo_mask;
        last_be  = single ? 4'h0 : hi_mask;
    end
endmodule

// File: rtl/dreq_tag_gen.sv
// Request tag counter; advances on each descriptor handshake and wraps
// at 2**NARROW_W unless extended tags are enabled (wrap at 2**TAG_W).
module dreq_tag_gen #(
    parameter int TAG_W    = 10,
    parameter int NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             ext_en,
    output logic [TAG_W-1:0] tag
);
    logic [NARROW_W-1:0] narrow_nxt;

    // Narrow increment keeps the upper bits clear in 8-bit mode.
    always_comb narrow_nxt = tag[NARROW_W-1:0] + 1'b1;

    // Tag register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      tag <= '0;
        else if (adv)    tag <= ext_en ? tag + 1'b1 : TAG_W'(narrow_nxt);
    end
endmodule

// File: rtl/dma_req_splitter.sv
// Splits a byte-addressed DMA command into DW-aligned memory request
// descriptors bounded by 4 KB pages and by the per-direction size limit.
// Assumes the size codes are held while a command is being accepted.
module dma_req_splitter #(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 32,
    parameter int TAG_W  = 10,
    localparam int PAGE_LG = dreq_pkg::PAGE_LG,
    localparam int CHK_W   = dreq_pkg::CHK_W,
    localparam int LEN_W   = PAGE_LG - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_bytes,
    input  logic              cmd_write,
    input  logic [2:0]        mps_code,
    input  logic [2:0]        mrrs_code,
    input  logic              ext_tag_en,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len_dw,
    output logic [3:0]        req_first_be,
    output logic [3:0]        req_last_be,
    output logic [TAG_W-1:0]  req_tag,
    output logic              req_write,
    output logic              done
);
    import dreq_pkg::*;

    split_st_e         state;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic [CHK_W-1:0]  lim;
    logic              is_wr;
    logic [CHK_W-1:0]  chunk;
    logic [1:0]        off;
    logic [1:0]        end_off;
    logic              fire;

    // Handshake and port views of the current state.
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        req_valid = (state == ST_BUSY);
        fire      = req_valid && req_ready;
        req_addr  = {cur_addr[ADDR_W-1:2], 2'b00};
        req_write = is_wr;
    end

    dreq_chunk_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_LG(PAGE_LG)) u_calc (
        .addr(cur_addr), .remain(remain), .limit(lim),
        .chunk(chunk), .len_dw(req_len_dw), .off(off), .end_off(end_off)
    );

    dreq_be_gen u_be (
        .off(off), .end_off(end_off), .single(req_len_dw == LEN_W'(1)),
        .first_be(req_first_be), .last_be(req_last_be)
    );

    dreq_tag_gen #(.TAG_W(TAG_W), .NARROW_W(8)) u_tag (
        .clk(clk), .rst_n(rst_n), .adv(fire), .ext_en(ext_tag_en), .tag(req_tag)
    );

    // Command capture, chunk advance and end-of-command pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            lim      <= CHK_W'(128);
            is_wr    <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (cmd_valid) begin
                    cur_addr <= cmd_addr;
                    remain   <= cmd_bytes;
                    is_wr    <= cmd_write;
                    lim      <= limit_of(cmd_write ? mps_code : mrrs_code);
                    if (cmd_bytes == '0) done  <= 1'b1;
                    else                 state <= ST_BUSY;
                end
            end else if (fire) begin
                cur_addr <= cur_addr + ADDR_W'(chunk);
                remain   <= remain - CNT_W'(chunk);
                if (remain == CNT_W'(chunk)) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end

    // R1: nothing is offered while a new command can be taken.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !req_valid);

    // R3: request stays inside one 4 KB page.
    p_no_page_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({2'b00, req_addr[PAGE_LG-1:0]} + {1'b0, req_len_dw, 2'b00})
                      <= (PAGE_LG+2)'(1 << PAGE_LG));

    // R4: DW-granular length never exceeds the latched size limit.
    p_size_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> {req_len_dw, 2'b00} <= (LEN_W+2)'(lim));

    // R5: single-DW request carries an empty last enable.
    p_single_last_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_len_dw == LEN_W'(1)) |-> (req_last_be == 4'h0 && req_first_be != 4'h0));

    // R6: multi-DW request enables are contiguous toward the inner DWs.
    p_contig_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_len_dw > LEN_W'(1)) |->
            (req_first_be inside {4'hF, 4'hE, 4'hC, 4'h8}) &&
            (req_last_be inside {4'h1, 4'h3, 4'h7, 4'hF}));

    // R8: a stalled descriptor holds still.
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
            $stable(req_len_dw) && $stable(req_first_be) &&
            $stable(req_last_be) && $stable(req_tag)));
endmodule

// File: tb/dma_req_splitter_tb.sv
module dma_req_splitter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [63:0] cmd_addr = '0;
    logic [31:0] cmd_bytes = '0;
    logic        cmd_write = 1'b0;
    logic [2:0]  mps_code = 3'd0;
    logic [2:0]  mrrs_code = 3'd0;
    logic        ext_tag_en = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [63:0] req_addr;
    logic [10:0] req_len_dw;
    logic [3:0]  req_first_be;
    logic [3:0]  req_last_be;
    logic [9:0]  req_tag;
    logic        req_write;
    logic        done;

    int checks = 0;
    int errors = 0;
    longint exp_tag = 0;

    always #2 clk = ~clk;

    dma_req_splitter u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .cmd_write(cmd_write),
        .mps_code(mps_code), .mrrs_code(mrrs_code), .ext_tag_en(ext_tag_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len_dw(req_len_dw), .req_first_be(req_first_be),
        .req_last_be(req_last_be), .req_tag(req_tag), .req_write(req_write),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic longint lim_of(input int code);
        return (code >= 5) ? 4096 : (128 << code);
    endfunction

    // Issue one command and check every descriptor against the model.
    task automatic run_cmd(input longint addr, input longint bytes, input bit wr,
                           input bit stall);
        longint a = addr;
        longint rem = bytes;
        int n = 0;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "ready when idle", cmd_ready, 1);
        cmd_addr = addr; cmd_bytes = 32'(bytes); cmd_write = wr; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (bytes == 0) begin
            chk(done == 1'b1, "R9", "done after zero-length", done, 1);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(req_valid == 1'b0, "R9", "no descriptor on zero-length", req_valid, 0);
                chk(done == 1'b0, "R9", "done single pulse", done, 0);
            end
            return;
        end
        chk(cmd_ready == 1'b0, "R1", "busy blocks commands", cmd_ready, 0);
        while (rem > 0) begin
            longint off = a & 3;
            longint pg = 4096 - (a & 4095);
            longint room = lim_of(wr ? int'(mps_code) : int'(mrrs_code)) - off;
            longint ch = rem;
            longint len;
            longint eo;
            logic [3:0] fbe;
            logic [3:0] lbe;
            if (pg < ch) ch = pg;
            if (room < ch) ch = room;
            len = (off + ch + 3) / 4;
            eo = (off + ch - 1) & 3;
            if (len == 1) begin
                fbe = 4'((4'hF >> (3 - eo)) & (4'hF << off)); lbe = 4'h0;
            end else begin
                fbe = 4'(4'hF << off); lbe = 4'(4'hF >> (3 - eo));
            end
            for (int w = 0; w < 20 && !req_valid; w++) @(negedge clk);
            chk(req_valid == 1'b1, "R2", "descriptor offered", req_valid, 1);
            chk(req_addr == 64'(a & ~64'd3), "R2", "aligned address", req_addr, a & ~64'd3);
            chk(req_len_dw == 11'(len), "R4", "length in DWs", req_len_dw, len);
            chk(req_first_be == fbe, len == 1 ? "R5" : "R6", "first BE", req_first_be, fbe);
            chk(req_last_be == lbe, len == 1 ? "R5" : "R6", "last BE", req_last_be, lbe);
            chk(req_tag == 10'(exp_tag), "R7", "tag", req_tag, exp_tag);
            chk(req_write == wr, "R2", "direction", req_write, wr);
            if (stall && (n % 2 == 0)) begin
                @(negedge clk);
                chk(req_valid && req_addr == 64'(a & ~64'd3) && req_len_dw == 11'(len)
                    && req_tag == 10'(exp_tag), "R8", "held under stall", req_len_dw, len);
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            exp_tag = ext_tag_en ? ((exp_tag + 1) & 1023) : ((exp_tag + 1) & 255);
            a += ch; rem -= ch; n++;
            chk(done == (rem == 0), "R9", "done timing", done, rem == 0);
        end
        @(negedge clk);
        chk(done == 1'b0 && cmd_ready == 1'b1, "R9", "done one cycle, idle again", done, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "reset ready", cmd_ready, 1);
        chk(req_valid == 1'b0, "R1", "reset no descriptor", req_valid, 0);
        chk(done == 1'b0, "R9", "reset no done", done, 0);
    endtask

    // R5: aligned 4 bytes -> len 1, first BE 1111.
    task automatic t_aligned_dw();  mps_code = 0; run_cmd(64'h1000, 4, 1, 0); endtask
    // R5: single byte at offset 2 -> first BE 0100.
    task automatic t_byte_off2();   mrrs_code = 0; run_cmd(64'h2002, 1, 0, 0); endtask
    // R6: 6 bytes from offset 1 -> len 2, 1110 / 0111.
    task automatic t_unaligned_span(); run_cmd(64'h3001, 6, 0, 1); endtask
    // R3: crossing a 4 KB page above 4 GB splits in two.
    task automatic t_page_cross();  mps_code = 5; run_cmd(64'h1_0000_0FF0, 64, 1, 1); endtask
    // R4: write split at 128 bytes with a 3-byte start offset.
    task automatic t_mps_offset();  mps_code = 0; run_cmd(64'h5003, 300, 1, 1); endtask
    // R4: read uses its own limit (256) and ignores the write limit.
    task automatic t_read_limit();  mps_code = 0; mrrs_code = 1; run_cmd(64'h6000, 1000, 0, 0); endtask
    // R4: code 7 clamps to 4096 and a whole aligned page goes in one request.
    task automatic t_code_clamp();  mps_code = 7; run_cmd(64'h8000, 4096, 1, 0); endtask
    // R9: zero byte count.
    task automatic t_zero();        run_cmd(64'h9000, 0, 1, 0); endtask
    // R7: 8-bit tag wrap.
    task automatic t_tag_wrap8();   ext_tag_en = 0; mps_code = 0; run_cmd(64'h10_0000, 300*128, 1, 0); endtask
    // R7: 10-bit tag wrap.
    task automatic t_tag_wrap10();  ext_tag_en = 1; mrrs_code = 0; run_cmd(64'h20_0000, 1100*128, 0, 0); endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_aligned_dw();
        t_byte_off2();
        t_unaligned_span();
        t_page_cross();
        t_mps_offset();
        t_read_limit();
        t_code_clamp();
        t_zero();
        t_tag_wrap8();
        t_tag_wrap10();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule